// File: doc/BRIEF.md
# Masked Burst Address Counter

This block generates the address for one port of a memory. A start address is loaded from the address inputs. After that the counter advances by one on every cycle in which the increment control is high. A mask register chooses which low address bits take part in counting. The upper bits keep their loaded value, so a burst wraps inside an aligned power-of-two block. A sticky active-low flag reports the first wrap.

A shadow register holds the last loaded start address. The retransmit control returns the counter to that address, so the same block can be replayed. A readback path returns either the counter or the mask on a registered output, one cycle after it is selected. A counter-clear control zeroes the counter without touching the mask. The master reset restores every piece of state.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst` is high at a clock edge, the counter becomes 0, the mask becomes all ones, `wrap_n` becomes 1 and `rb_data` becomes 0.
- R2: `cnt_load` puts `addr_in` on `addr_out` after the next edge and records it as the retransmit start address.
- R3: `cnt_inc` adds one to the masked low field, modulo 2^k for a mask of k ones. Bits outside the mask keep their value.
- R4: An increment taken while the masked field is all ones drives `wrap_n` low after the edge. It stays low through later increments, retransmits and idle cycles.
- R5: `cnt_load` or `cnt_clr` returns `wrap_n` to 1.
- R6: `cnt_clr` sets the counter to 0 and clears the flag. It leaves the mask and the retransmit start address as they were.
- R7: `cnt_retx` returns the counter to the last loaded address and does not change `wrap_n`.
- R8: `mask_wr` stores `addr_in` as the mask only when the value is 2^k-1 for some k from 0 to ADDR_W. Any other value is ignored and the old mask stays.
- R9: In one cycle the counter obeys clear first, then load, then retransmit, then increment, then hold. A mask write in the same cycle as an increment takes effect only after that increment, which uses the old mask.
- R10: `rb_data` shows the mask when `rb_sel_mask` is 1 and the counter when it is 0. The value shown is the one held before the edge that registers it.
- R11: With an all-zero mask, an increment leaves the counter unchanged and counts as a wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high master reset |
| addr_in | input | ADDR_W | Start address for a load; mask value for a mask write |
| cnt_clr | input | 1 | Set counter to zero and clear the wrap flag |
| cnt_load | input | 1 | Load the counter and the shadow from `addr_in` |
| cnt_retx | input | 1 | Return the counter to the shadow address |
| cnt_inc | input | 1 | Advance the counter inside the mask |
| mask_wr | input | 1 | Write the mask from `addr_in` if the value is legal |
| rb_sel_mask | input | 1 | Readback select: 1 mask, 0 counter |
| addr_out | output | ADDR_W | Current counter value |
| rb_data | output | ADDR_W | Registered readback value |
| wrap_n | output | 1 | Sticky active-low wrap flag |

## Verification
Two pairs of operations can fall in the same cycle. The first pair is a mask write and an increment. The bench programs a wide mask, loads an address that sits just below a narrow block boundary, then asserts the increment together with a mask write of a narrower value. The counter must carry past the narrow boundary, which shows the old mask was used; the next increments must then wrap inside the new field. The second pair is the four counter controls raised together in several combinations. Each result is compared against the value the priority order predicts. Every legal mask is also swept against every start address, and the expected counts and wrap cycles are computed with modular arithmetic.

// File: rtl/bag_pkg.sv
package bag_pkg;

  typedef enum logic [2:0] {
    OP_HOLD = 3'd0,
    OP_INC  = 3'd1,
    OP_RETX = 3'd2,
    OP_LOAD = 3'd3,
    OP_CLR  = 3'd4
  } cnt_op_e;

  // Fixed priority among the counter controls (R9)
  function automatic cnt_op_e pick_op(input logic clr, input logic load,
                                      input logic retx, input logic inc);
    cnt_op_e op;
    if (clr)       op = OP_CLR;
    else if (load) op = OP_LOAD;
    else if (retx) op = OP_RETX;
    else if (inc)  op = OP_INC;
    else           op = OP_HOLD;
    return op;
  endfunction

endpackage

// File: rtl/bag_mask_reg.sv
module bag_mask_reg #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [ADDR_W-1:0] din,
  output logic [ADDR_W-1:0] mask
);

  logic [ADDR_W-1:0] mask_q;
  logic [ADDR_W-1:0] din_p1;
  logic              din_legal;

  // Legal mask: a run of ones starting at bit 0 (an empty run is allowed)
  assign din_p1    = din + {{(ADDR_W-1){1'b0}}, 1'b1};
  assign din_legal = ((din & din_p1) == '0);

  always_ff @(posedge clk) begin
    if (rst)                 mask_q <= '1;
    else if (wr && din_legal) mask_q <= din;
  end

  assign mask = mask_q;

  a_r1_mask_reset: assert property (@(posedge clk) rst |=> (mask_q == '1));

  a_r8_mask_contig: assert property (@(posedge clk) disable iff (rst)
    ((mask_q & (mask_q + {{(ADDR_W-1){1'b0}}, 1'b1})) == '0));

  a_r8_no_write_stable: assert property (@(posedge clk) disable iff (rst)
    !wr |=> $stable(mask_q));

endmodule

// File: rtl/bag_counter.sv
module bag_counter
  import bag_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  cnt_op_e           op,
  input  logic [ADDR_W-1:0] din,
  input  logic [ADDR_W-1:0] mask,
  output logic [ADDR_W-1:0] cnt,
  output logic              wrap_n
);

  logic [ADDR_W-1:0] cnt_q;
  logic [ADDR_W-1:0] shadow_q;
  logic              wrap_n_q;
  logic [ADDR_W-1:0] cnt_plus;
  logic [ADDR_W-1:0] cnt_stepped;
  logic              field_full;

  assign cnt_plus    = cnt_q + {{(ADDR_W-1){1'b0}}, 1'b1};
  // Bits outside the mask keep their value; the carry out of the field is dropped
  assign cnt_stepped = (cnt_q & ~mask) | (cnt_plus & mask);
  assign field_full  = ((cnt_q & mask) == mask);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      shadow_q <= '0;
      wrap_n_q <= 1'b1;
    end else begin
      unique case (op)
        OP_CLR: begin
          cnt_q    <= '0;
          wrap_n_q <= 1'b1;
        end
        OP_LOAD: begin
          cnt_q    <= din;
          shadow_q <= din;
          wrap_n_q <= 1'b1;
        end
        OP_RETX: cnt_q <= shadow_q;
        OP_INC: begin
          cnt_q <= cnt_stepped;
          if (field_full) wrap_n_q <= 1'b0;
        end
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign cnt    = cnt_q;
  assign wrap_n = wrap_n_q;

  a_r1_cnt_reset: assert property (@(posedge clk)
    rst |=> (cnt_q == '0) && wrap_n_q);

  a_r2_load: assert property (@(posedge clk) disable iff (rst)
    (op == OP_LOAD) |=> (cnt_q == $past(din)) && wrap_n_q);

  a_r3_upper_hold: assert property (@(posedge clk) disable iff (rst)
    (op == OP_INC) |=> ((cnt_q & ~$past(mask)) == ($past(cnt_q) & ~$past(mask))));

  a_r4_sticky: assert property (@(posedge clk) disable iff (rst)
    (!wrap_n_q && (op != OP_CLR) && (op != OP_LOAD)) |=> !wrap_n_q);

  a_r6_clear: assert property (@(posedge clk) disable iff (rst)
    (op == OP_CLR) |=> (cnt_q == '0) && wrap_n_q && $stable(shadow_q));

  a_r7_retx: assert property (@(posedge clk) disable iff (rst)
    (op == OP_RETX) |=> (cnt_q == $past(shadow_q)) && $stable(wrap_n_q));

endmodule

// File: rtl/bag_readback.sv
module bag_readback #(
  parameter int ADDR_W = 16,
  parameter bit RB_REG = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_mask,
  input  logic [ADDR_W-1:0] cnt,
  input  logic [ADDR_W-1:0] mask,
  output logic [ADDR_W-1:0] rb
);

  logic [ADDR_W-1:0] pick;
  assign pick = sel_mask ? mask : cnt;

  generate
    if (RB_REG) begin : g_reg
      logic [ADDR_W-1:0] rb_q;
      always_ff @(posedge clk) begin
        if (rst) rb_q <= '0;
        else     rb_q <= pick;
      end
      assign rb = rb_q;
    end else begin : g_comb
      assign rb = pick;
    end
  endgenerate

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import bag_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter bit RB_REG = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              cnt_clr,
  input  logic              cnt_load,
  input  logic              cnt_retx,
  input  logic              cnt_inc,
  input  logic              mask_wr,
  input  logic              rb_sel_mask,
  output logic [ADDR_W-1:0] addr_out,
  output logic [ADDR_W-1:0] rb_data,
  output logic              wrap_n
);

  cnt_op_e           op;
  logic [ADDR_W-1:0] mask;
  logic [ADDR_W-1:0] cnt;

  assign op = pick_op(cnt_clr, cnt_load, cnt_retx, cnt_inc);

  bag_mask_reg #(.ADDR_W(ADDR_W)) u_mask (
    .clk  (clk),
    .rst  (rst),
    .wr   (mask_wr),
    .din  (addr_in),
    .mask (mask)
  );

  bag_counter #(.ADDR_W(ADDR_W)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .op     (op),
    .din    (addr_in),
    .mask   (mask),
    .cnt    (cnt),
    .wrap_n (wrap_n)
  );

  bag_readback #(.ADDR_W(ADDR_W), .RB_REG(RB_REG)) u_rb (
    .clk      (clk),
    .rst      (rst),
    .sel_mask (rb_sel_mask),
    .cnt      (cnt),
    .mask     (mask),
    .rb       (rb_data)
  );

  assign addr_out = cnt;

  a_r9_clear_wins: assert property (@(posedge clk) disable iff (rst)
    cnt_clr |=> (addr_out == '0) && wrap_n);

  a_r9_load_over_retx: assert property (@(posedge clk) disable iff (rst)
    (!cnt_clr && cnt_load) |=> (addr_out == $past(addr_in)));

endmodule

// File: tb/burst_addr_gen_tb.sv
module burst_addr_gen_tb;
  localparam int AW = 4;
  localparam int N  = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] addr_in = '0;
  logic          cnt_clr = 0, cnt_load = 0, cnt_retx = 0, cnt_inc = 0;
  logic          mask_wr = 0, rb_sel_mask = 0;
  logic [AW-1:0] addr_out, rb_data;
  logic          wrap_n;
  int            vectors = 0;
  int            errors  = 0;

  always #2.5 clk = ~clk;

  burst_addr_gen #(.ADDR_W(AW), .RB_REG(1'b1)) u_dut (
    .clk(clk), .rst(rst), .addr_in(addr_in),
    .cnt_clr(cnt_clr), .cnt_load(cnt_load), .cnt_retx(cnt_retx),
    .cnt_inc(cnt_inc), .mask_wr(mask_wr), .rb_sel_mask(rb_sel_mask),
    .addr_out(addr_out), .rb_data(rb_data), .wrap_n(wrap_n)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    cnt_clr = 0; cnt_load = 0; cnt_retx = 0; cnt_inc = 0; mask_wr = 0;
  endtask

  task automatic write_mask(input int v);
    idle(); addr_in = AW'(v); mask_wr = 1; tick(); mask_wr = 0;
  endtask

  task automatic load(input int a);
    idle(); addr_in = AW'(a); cnt_load = 1; tick(); cnt_load = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    // R1: reset state
    rst = 1; tick(); tick();
    chk("R1 counter", addr_out, 0);
    chk("R1 flag", wrap_n, 1);
    chk("R1 rb", rb_data, 0);
    rst = 0; rb_sel_mask = 1; tick();
    chk("R1 mask all ones (R10 readback)", rb_data, N - 1);

    // R3/R4/R11 sweep over every legal mask and start address
    for (int k = 0; k <= AW; k++) begin
      int m;
      m = (1 << k) - 1;
      write_mask(m);
      rb_sel_mask = 1; tick();
      chk("R8 legal mask stored", rb_data, m);
      for (int a = 0; a < N; a++) begin
        load(a);
        chk("R2 load", addr_out, a);
        chk("R5 load clears flag", wrap_n, 1);
        cnt_inc = 1;
        for (int n = 1; n <= m + 2; n++) begin
          int ex;
          tick();
          ex = (a & ~m & (N - 1)) | (((a & m) + n) % (m + 1));
          chk("R3 increment", addr_out, ex);
          chk("R4 R11 wrap flag", wrap_n, (((a & m) + n) >= (m + 1)) ? 0 : 1);
        end
        idle(); cnt_retx = 1; tick(); cnt_retx = 0;
        chk("R7 retransmit", addr_out, a);
        chk("R7 flag kept", wrap_n, 0);
        rb_sel_mask = 0; tick();
        chk("R10 counter readback", rb_data, a);
        chk("R4 sticky idle", wrap_n, 0);
        cnt_clr = 1; tick(); cnt_clr = 0;
        chk("R6 clear counter", addr_out, 0);
        chk("R6 R5 clear flag", wrap_n, 1);
        cnt_retx = 1; tick(); cnt_retx = 0;
        chk("R6 shadow kept", addr_out, a);
        rb_sel_mask = 1; tick();
        chk("R6 mask kept", rb_data, m);
      end
    end

    // R8: every write value against a known legal mask
    for (int v = 0; v < N; v++) begin
      int legal;
      legal = 0;
      for (int p = 0; p <= AW; p++) if (v + 1 == (1 << p)) legal = 1;
      write_mask(3);
      write_mask(v);
      rb_sel_mask = 1; tick();
      chk("R8 mask write filter", rb_data, legal ? v : 3);
    end

    // R9: priority among simultaneous counter controls
    write_mask(N - 1);
    load(5);
    addr_in = 4'h9; cnt_clr = 1; cnt_load = 1; cnt_retx = 1; cnt_inc = 1; tick(); idle();
    chk("R9 clear over all", addr_out, 0);
    addr_in = 4'h9; cnt_load = 1; cnt_retx = 1; cnt_inc = 1; tick(); idle();
    chk("R9 load over retx/inc", addr_out, 9);
    cnt_inc = 1; tick(); tick(); idle();
    chk("R9 inc alone", addr_out, 11);
    cnt_retx = 1; cnt_inc = 1; tick(); idle();
    chk("R9 retx over inc", addr_out, 9);

    // R9: mask write and increment in the same cycle use the old mask
    load(7);
    addr_in = 4'h1; mask_wr = 1; cnt_inc = 1; tick(); idle();
    chk("R9 inc uses old mask", addr_out, 8);
    chk("R9 no wrap under old mask", wrap_n, 1);
    cnt_inc = 1; tick();
    chk("R9 new mask step", addr_out, 9);
    tick(); idle();
    chk("R9 new mask wrap", addr_out, 8);
    chk("R4 wrap in new field", wrap_n, 0);
    load(2);
    chk("R5 load clears set flag", wrap_n, 1);

    // R1: master reset from a busy state
    write_mask(1); cnt_inc = 1; tick(); tick(); idle();
    rst = 1; tick(); rst = 0; rb_sel_mask = 1; tick();
    chk("R1 reset counter", addr_out, 0);
    chk("R1 reset flag", wrap_n, 1);
    chk("R1 reset mask", rb_data, N - 1);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule